// File: doc/BRIEF.md
# Sub-Word Register Access Adapter

This adapter connects a byte-addressed 128-byte I/O window to register targets that only accept whole 32-bit words. Each request names a byte address, a size of one to four bytes and, for a write, the new bytes. The adapter decodes the address into one of three targets: a bank of sixteen core registers, a bank of eight DMA registers, or a single bus-control register. Addresses in the gaps are unmapped.

A write that covers less than a full aligned word is turned into a full-word write. The adapter reads the live target word, replaces only the addressed byte lanes and writes the whole word back at the aligned index. Reads fetch the whole word and return it shifted and masked down to the requested width, with zero for unmapped addresses. Write strobes and read responses appear one cycle after the request. A request that follows a write to the same register in the next cycle sees the value just written.

Top module: `sw_access_adapter`

## Requirements
- R1: While and after reset, with no request presented, `core_wr_en`, `dma_wr_en`, `ctl_wr_en` and `rsp_valid` are low.
- R2: Byte addresses 0x00 to 0x3F select the core bank at word index address/4 (`core_wr_en`, `wr_idx`, `core_rd_idx`).
- R3: Byte addresses 0x40 to 0x5F select the DMA bank at word index (address − 0x40)/4 (`dma_wr_en`, `wr_idx`, `dma_rd_idx`).
- R4: Writes anywhere in 0x70 to 0x73 reach the bus-control register. Reads return the bus-control word only at exactly 0x70. Reads at any other address from 0x60 upward return 0.
- R5: Writes to 0x60 to 0x6F and 0x74 to 0x7F raise no write strobe and leave every target unchanged.
- R6: `req_size` encodes bytes minus one (0 = one byte, 3 = four bytes). Byte k of `req_wdata` (bits 8k+7:8k) goes to byte offset (address mod 4)+k of the target word. All other bytes keep their current value, and the write goes to the aligned word.
- R7: A four-byte write at an aligned address passes `req_wdata` to `wr_data` unchanged.
- R8: A read returns the target word shifted right by 8 × (address mod 4) bits and masked to 8 × (size+1) bits.
- R9: Bytes of an access that would fall beyond the addressed word are dropped. Such writes change only the bytes inside the word, and such reads return zeros in the upper bytes.
- R10: A write strobe or read response is a one-cycle pulse in the cycle after the request. Write requests produce no response.
- R11: A request in the cycle right after a write to the same register merges with, or reads, the value that write carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte address in the window |
| req_size | input | 2 | Access bytes minus one |
| req_wdata | input | 32 | Write bytes, first byte in bits 7:0 |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, right-aligned |
| core_rd_idx | output | 4 | Core bank read index |
| core_rd_data | input | 32 | Current core word at `core_rd_idx` |
| dma_rd_idx | output | 3 | DMA bank read index |
| dma_rd_data | input | 32 | Current DMA word at `dma_rd_idx` |
| ctl_rd_data | input | 32 | Current bus-control word |
| wr_idx | output | 4 | Word index of the write strobe |
| wr_data | output | 32 | Full merged word to write |
| core_wr_en | output | 1 | Write strobe for the core bank |
| dma_wr_en | output | 1 | Write strobe for the DMA bank |
| ctl_wr_en | output | 1 | Write strobe for bus-control |

## Verification
A fault in the decode shows up in the cycle after the request, as a strobe on the wrong bank, a wrong `wr_idx`, or a non-zero read of an unmapped address. A wrong lane mask or shift corrupts neighbouring bytes. That damage appears in the same strobe's `wr_data` and again on any later read of the word. A fault in the pending-write forwarding only appears when two accesses to one register come in back-to-back cycles. It then shows as a lost byte in the second strobe, or as stale read data one cycle later.

// File: rtl/sw_adapt_pkg.sv
`timescale 1ns/1ps
package sw_adapt_pkg;
    localparam int WIN_AW     = 7;
    localparam int WORD_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = WORD_W / BYTE_W;
    localparam int OFF_W      = $clog2(WORD_BYTES);
    localparam int SIZE_W     = OFF_W;
    localparam int CORE_WORDS = 16;
    localparam int DMA_WORDS  = 8;
    localparam int CORE_IDX_W = $clog2(CORE_WORDS);
    localparam int DMA_IDX_W  = $clog2(DMA_WORDS);
    localparam int IDX_W      = (CORE_IDX_W > DMA_IDX_W) ? CORE_IDX_W : DMA_IDX_W;
    localparam logic [WIN_AW-1:0] DMA_BASE = WIN_AW'(CORE_WORDS * WORD_BYTES);
    localparam logic [WIN_AW-1:0] DMA_END  = WIN_AW'(CORE_WORDS * WORD_BYTES + DMA_WORDS * WORD_BYTES);
    localparam logic [WIN_AW-1:0] CTL_ADDR = 7'h70;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CORE = 2'd1,
        RGN_DMA  = 2'd2,
        RGN_CTL  = 2'd3
    } region_e;

    typedef struct packed {
        region_e          rgn;
        logic [IDX_W-1:0] idx;
    } target_t;

    // ones in the low (size+1) bytes
    function automatic logic [WORD_W-1:0] width_mask(input logic [SIZE_W-1:0] size);
        logic [WORD_W-1:0] one;
        int nbits;
        one   = 1;
        nbits = BYTE_W * (int'(size) + 1);
        if (nbits >= WORD_W) return '1;
        return (one << nbits) - one;
    endfunction

    // byte lanes touched inside the word; lanes past the word fall off the top
    function automatic logic [WORD_W-1:0] lane_mask(input logic [OFF_W-1:0] off,
                                                    input logic [SIZE_W-1:0] size);
        return width_mask(size) << (BYTE_W * int'(off));
    endfunction

    function automatic logic [WORD_W-1:0] read_align(input logic [WORD_W-1:0] word,
                                                     input logic [OFF_W-1:0] off,
                                                     input logic [SIZE_W-1:0] size);
        return (word >> (BYTE_W * int'(off))) & width_mask(size);
    endfunction
endpackage

// File: rtl/sw_decode.sv
`timescale 1ns/1ps
module sw_decode
    import sw_adapt_pkg::*;
(
    input  logic [WIN_AW-1:0] addr,
    input  logic              is_write,
    output target_t           tgt
);
    logic [WIN_AW-1:0] rel_dma;
    logic              ctl_hit;

    always_comb begin
        rel_dma = addr - DMA_BASE;
        // writes match the whole aligned word, reads only the exact byte address
        ctl_hit = is_write ? (addr[WIN_AW-1:OFF_W] == CTL_ADDR[WIN_AW-1:OFF_W])
                           : (addr == CTL_ADDR);
        tgt.rgn = RGN_NONE;
        tgt.idx = '0;
        if (addr < DMA_BASE) begin
            tgt.rgn = RGN_CORE;
            tgt.idx = IDX_W'(addr >> OFF_W);
        end else if (addr < DMA_END) begin
            tgt.rgn = RGN_DMA;
            tgt.idx = IDX_W'(rel_dma >> OFF_W);
        end else if (ctl_hit) begin
            tgt.rgn = RGN_CTL;
        end
    end
endmodule

// File: rtl/sw_fetch.sv
`timescale 1ns/1ps
module sw_fetch
    import sw_adapt_pkg::*;
(
    input  target_t           tgt,
    input  logic [WORD_W-1:0] core_word,
    input  logic [WORD_W-1:0] dma_word,
    input  logic [WORD_W-1:0] ctl_word,
    input  target_t           pend_tgt,
    input  logic [WORD_W-1:0] pend_data,
    output logic [WORD_W-1:0] cur
);
    logic fwd;

    always_comb begin
        fwd = (pend_tgt.rgn != RGN_NONE) && (pend_tgt == tgt);
        unique case (tgt.rgn)
            RGN_CORE: cur = core_word;
            RGN_DMA:  cur = dma_word;
            RGN_CTL:  cur = ctl_word;
            default:  cur = '0;
        endcase
        // the target has not yet absorbed last cycle's strobe
        if (fwd) cur = pend_data;
    end
endmodule

// File: rtl/sw_merge.sv
`timescale 1ns/1ps
module sw_merge
    import sw_adapt_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic [WORD_W-1:0] wdata,
    input  logic [OFF_W-1:0]  off,
    input  logic [SIZE_W-1:0] size,
    output logic [WORD_W-1:0] merged
);
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] placed;

    always_comb begin
        mask   = lane_mask(off, size);
        placed = wdata << (BYTE_W * int'(off));
        merged = (cur & ~mask) | (placed & mask);
    end
endmodule

// File: rtl/sw_access_adapter.sv
`timescale 1ns/1ps
module sw_access_adapter
    import sw_adapt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [WIN_AW-1:0]     req_addr,
    input  logic [SIZE_W-1:0]     req_size,
    input  logic [WORD_W-1:0]     req_wdata,
    output logic                  rsp_valid,
    output logic [WORD_W-1:0]     rsp_rdata,
    output logic [CORE_IDX_W-1:0] core_rd_idx,
    input  logic [WORD_W-1:0]     core_rd_data,
    output logic [DMA_IDX_W-1:0]  dma_rd_idx,
    input  logic [WORD_W-1:0]     dma_rd_data,
    input  logic [WORD_W-1:0]     ctl_rd_data,
    output logic [IDX_W-1:0]      wr_idx,
    output logic [WORD_W-1:0]     wr_data,
    output logic                  core_wr_en,
    output logic                  dma_wr_en,
    output logic                  ctl_wr_en
);
    target_t           tgt;
    target_t           wr_q;
    logic [WORD_W-1:0] wr_data_q;
    logic [WORD_W-1:0] cur;
    logic [WORD_W-1:0] merged;
    logic              rsp_valid_q;
    logic [WORD_W-1:0] rsp_data_q;
    logic [OFF_W-1:0]  off;

    assign off = req_addr[OFF_W-1:0];

    sw_decode u_decode (
        .addr     (req_addr),
        .is_write (req_write),
        .tgt      (tgt)
    );

    assign core_rd_idx = tgt.idx[CORE_IDX_W-1:0];
    assign dma_rd_idx  = tgt.idx[DMA_IDX_W-1:0];

    sw_fetch u_fetch (
        .tgt       (tgt),
        .core_word (core_rd_data),
        .dma_word  (dma_rd_data),
        .ctl_word  (ctl_rd_data),
        .pend_tgt  (wr_q),
        .pend_data (wr_data_q),
        .cur       (cur)
    );

    sw_merge u_merge (
        .cur    (cur),
        .wdata  (req_wdata),
        .off    (off),
        .size   (req_size),
        .merged (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q        <= '{rgn: RGN_NONE, idx: '0};
            wr_data_q   <= '0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            if (req_valid && req_write && tgt.rgn != RGN_NONE) begin
                wr_q      <= tgt;
                wr_data_q <= merged;
            end else begin
                wr_q.rgn  <= RGN_NONE;
            end
            rsp_valid_q <= req_valid && !req_write;
            if (req_valid && !req_write) begin
                rsp_data_q <= read_align(cur, off, req_size);
            end
        end
    end

    assign core_wr_en = (wr_q.rgn == RGN_CORE);
    assign dma_wr_en  = (wr_q.rgn == RGN_DMA);
    assign ctl_wr_en  = (wr_q.rgn == RGN_CTL);
    assign wr_idx     = wr_q.idx;
    assign wr_data    = wr_data_q;
    assign rsp_valid  = rsp_valid_q;
    assign rsp_rdata  = rsp_data_q;

    AST_WR_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr < DMA_END) |=> (core_wr_en || dma_wr_en)); // R10
    AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid); // R10
    AST_NO_RSP_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid); // R10
    AST_GAP_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr >= DMA_END && req_addr < CTL_ADDR)
        |=> !(core_wr_en || dma_wr_en || ctl_wr_en)); // R5
    AST_GAP_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr >= DMA_END && req_addr != CTL_ADDR)
        |=> (rsp_rdata == '0)); // R4
    AST_FULL_WORD_PASS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_size == '1 && off == '0 && req_addr < DMA_END)
        |=> (wr_data == $past(req_wdata))); // R7
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({core_wr_en, dma_wr_en, ctl_wr_en})); // R2
endmodule

// File: tb/sw_access_adapter_bench.sv
`timescale 1ns/1ps
module sw_access_adapter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [3:0]  core_rd_idx;
    logic [31:0] core_rd_data;
    logic [2:0]  dma_rd_idx;
    logic [31:0] dma_rd_data;
    logic [31:0] ctl_rd_data;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;
    logic        core_wr_en, dma_wr_en, ctl_wr_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // simple register targets
    logic [31:0] core_t [16];
    logic [31:0] dma_t [8];
    logic [31:0] ctl_t;
    assign core_rd_data = core_t[core_rd_idx];
    assign dma_rd_data  = dma_t[dma_rd_idx];
    assign ctl_rd_data  = ctl_t;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) core_t[i] <= 32'hC0DE_0000 + i;
            for (int i = 0; i < 8; i++)  dma_t[i]  <= 32'hD0A0_0000 + i;
            ctl_t <= 32'h5A5A_C3C3;
        end else begin
            if (core_wr_en) core_t[wr_idx] <= wr_data;
            if (dma_wr_en)  dma_t[wr_idx[2:0]] <= wr_data;
            if (ctl_wr_en)  ctl_t <= wr_data;
        end
    end

    sw_access_adapter u_sw_access_adapter (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .core_rd_idx(core_rd_idx), .core_rd_data(core_rd_data),
        .dma_rd_idx(dma_rd_idx), .dma_rd_data(dma_rd_data),
        .ctl_rd_data(ctl_rd_data), .wr_idx(wr_idx), .wr_data(wr_data),
        .core_wr_en(core_wr_en), .dma_wr_en(dma_wr_en), .ctl_wr_en(ctl_wr_en)
    );

    // shadow model built from the requirements
    logic [31:0] m_core [16];
    logic [31:0] m_dma [8];
    logic [31:0] m_ctl;

    function automatic int bregion(input logic [6:0] a, input bit wr);
        if (a < 7'h40) return 1;
        if (a < 7'h60) return 2;
        if (wr && a[6:2] == 5'd28) return 3;
        if (!wr && a == 7'h70) return 3;
        return 0;
    endfunction

    function automatic int bindex(input logic [6:0] a);
        if (a < 7'h40) return int'(a) / 4;
        return (int'(a) - 64) / 4;
    endfunction

    function automatic logic [31:0] mword(input logic [6:0] a, input bit wr);
        case (bregion(a, wr))
            1: return m_core[bindex(a)];
            2: return m_dma[bindex(a)];
            3: return m_ctl;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_merge(input logic [31:0] old, input logic [6:0] a,
                                              input logic [1:0] sz, input logic [31:0] d);
        logic [31:0] r = old;
        for (int k = 0; k <= int'(sz); k++) begin
            int pos = int'(a[1:0]) + k;
            if (pos < 4) r[8*pos +: 8] = d[8*k +: 8];
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] w, input logic [6:0] a,
                                             input logic [1:0] sz);
        logic [31:0] r = 32'h0;
        for (int k = 0; k <= int'(sz); k++) begin
            int pos = int'(a[1:0]) + k;
            if (pos < 4) r[8*k +: 8] = w[8*pos +: 8];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare one captured cycle against the model and update the model
    task automatic verify(input string tag, input bit wr, input logic [6:0] a,
                          input logic [1:0] sz, input logic [31:0] d,
                          input logic c_rv, input logic [31:0] c_rd,
                          input logic [2:0] c_en, input logic [3:0] c_idx,
                          input logic [31:0] c_wd);
        int rg = bregion(a, wr);
        if (wr) begin
            logic [31:0] nw = exp_merge(mword(a, 1'b1), a, sz, d);
            logic [2:0] en_exp = (rg == 1) ? 3'b100 : (rg == 2) ? 3'b010 : (rg == 3) ? 3'b001 : 3'b000;
            check({tag, " strobe"}, {29'h0, c_en}, {29'h0, en_exp});
            check({tag, " no-rsp R10"}, {31'h0, c_rv}, 32'h0);
            if (rg == 1 || rg == 2) check({tag, " idx"}, {28'h0, c_idx}, bindex(a));
            if (rg != 0) check({tag, " data"}, c_wd, nw);
            if (rg == 1) m_core[bindex(a)] = nw;
            if (rg == 2) m_dma[bindex(a)] = nw;
            if (rg == 3) m_ctl = nw;
        end else begin
            check({tag, " rsp_valid"}, {31'h0, c_rv}, 32'h1);
            check({tag, " rdata"}, c_rd, exp_read(mword(a, 1'b0), a, sz));
            check({tag, " no-strobe"}, {29'h0, c_en}, 32'h0);
        end
    endtask

    task automatic drive(input bit wr, input logic [6:0] a, input logic [1:0] sz,
                         input logic [31:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    endtask

    task automatic access(input string tag, input bit wr, input logic [6:0] a,
                          input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        drive(wr, a, sz, d);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        verify(tag, wr, a, sz, d, rsp_valid, rsp_rdata,
               {core_wr_en, dma_wr_en, ctl_wr_en}, wr_idx, wr_data);
    endtask

    task automatic pair(input string tag, input bit w1, input logic [6:0] a1,
                        input logic [1:0] s1, input logic [31:0] d1, input bit w2,
                        input logic [6:0] a2, input logic [1:0] s2, input logic [31:0] d2);
        logic rv; logic [31:0] rd; logic [2:0] en; logic [3:0] ix; logic [31:0] wd;
        @(negedge clk);
        drive(w1, a1, s1, d1);
        @(posedge clk);
        #1;
        rv = rsp_valid; rd = rsp_rdata; en = {core_wr_en, dma_wr_en, ctl_wr_en};
        ix = wr_idx; wd = wr_data;
        drive(w2, a2, s2, d2);
        verify({tag, " first"}, w1, a1, s1, d1, rv, rd, en, ix, wd);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        verify({tag, " second"}, w2, a2, s2, d2, rsp_valid, rsp_rdata,
               {core_wr_en, dma_wr_en, ctl_wr_en}, wr_idx, wr_data);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 16; i++) m_core[i] = 32'hC0DE_0000 + i;
        for (int i = 0; i < 8; i++)  m_dma[i]  = 32'hD0A0_0000 + i;
        m_ctl = 32'h5A5A_C3C3;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 strobes in reset", {29'h0, core_wr_en, dma_wr_en, ctl_wr_en}, 32'h0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 strobes after reset", {29'h0, core_wr_en, dma_wr_en, ctl_wr_en}, 32'h0);
        check("R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic t_core_full();
        access("R2 R7 core full write", 1'b1, 7'h08, 2'd3, 32'h1234_5678);
        access("R2 R8 core full read", 1'b0, 7'h08, 2'd3, 32'h0);
        access("R2 core last word read", 1'b0, 7'h3C, 2'd3, 32'h0);
    endtask

    task automatic t_dma();
        access("R3 R6 dma byte write", 1'b1, 7'h45, 2'd0, 32'h0000_00EE);
        access("R3 dma word read", 1'b0, 7'h44, 2'd3, 32'h0);
        access("R3 dma top word write", 1'b1, 7'h5C, 2'd3, 32'hCAFE_F00D);
        access("R3 dma top word read", 1'b0, 7'h5C, 2'd3, 32'h0);
    endtask

    task automatic t_partial();
        access("R6 half write off2", 1'b1, 7'h12, 2'd1, 32'h0000_BEEF);
        access("R6 word read after half", 1'b0, 7'h10, 2'd3, 32'h0);
        access("R8 byte read off3", 1'b0, 7'h13, 2'd0, 32'h0);
        access("R8 half read off1", 1'b0, 7'h11, 2'd1, 32'h0);
        access("R6 three-byte write off1", 1'b1, 7'h29, 2'd2, 32'h00AB_CDEF);
        access("R6 word read after three", 1'b0, 7'h28, 2'd3, 32'h0);
    endtask

    task automatic t_ctl();
        access("R4 ctl byte write at 0x71", 1'b1, 7'h71, 2'd0, 32'h0000_0077);
        access("R4 ctl read at 0x70", 1'b0, 7'h70, 2'd3, 32'h0);
        access("R4 read at 0x71 is zero", 1'b0, 7'h71, 2'd0, 32'h0);
        access("R4 read at 0x62 is zero", 1'b0, 7'h62, 2'd1, 32'h0);
    endtask

    task automatic t_invalid();
        access("R5 write at 0x64 dropped", 1'b1, 7'h64, 2'd3, 32'hFFFF_FFFF);
        access("R5 write at 0x74 dropped", 1'b1, 7'h74, 2'd3, 32'hFFFF_FFFF);
        access("R5 write at 0x7F dropped", 1'b1, 7'h7F, 2'd0, 32'h0000_00FF);
        access("R5 ctl unchanged", 1'b0, 7'h70, 2'd3, 32'h0);
        access("R5 dma top unchanged", 1'b0, 7'h5C, 2'd3, 32'h0);
        access("R4 read at 0x7C is zero", 1'b0, 7'h7C, 2'd3, 32'h0);
    endtask

    task automatic t_trunc();
        access("R9 word write off2 truncated", 1'b1, 7'h1E, 2'd3, 32'h4433_2211);
        access("R9 neighbour word untouched", 1'b0, 7'h20, 2'd3, 32'h0);
        access("R9 word read off1 zero top", 1'b0, 7'h1D, 2'd3, 32'h0);
        access("R9 word read at aligned", 1'b0, 7'h1C, 2'd3, 32'h0);
    endtask

    task automatic t_latency();
        access("R10 strobe cycle", 1'b1, 7'h04, 2'd3, 32'h0BAD_CAFE);
        @(posedge clk);
        #1;
        check("R10 strobe is one cycle", {29'h0, core_wr_en, dma_wr_en, ctl_wr_en}, 32'h0);
        access("R10 rsp cycle", 1'b0, 7'h04, 2'd3, 32'h0);
        @(posedge clk);
        #1;
        check("R10 rsp is one cycle", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic t_b2b();
        pair("R11 byte then byte", 1'b1, 7'h30, 2'd0, 32'h11, 1'b1, 7'h31, 2'd0, 32'h22);
        access("R11 read after pair", 1'b0, 7'h30, 2'd3, 32'h0);
        pair("R11 write then read", 1'b1, 7'h4A, 2'd1, 32'h9876, 1'b0, 7'h48, 2'd3, 32'h0);
        pair("R11 ctl byte then byte", 1'b1, 7'h72, 2'd0, 32'h44, 1'b1, 7'h73, 2'd0, 32'h55);
        access("R11 ctl read after pair", 1'b0, 7'h70, 2'd3, 32'h0);
        pair("R11 other word no forward", 1'b1, 7'h34, 2'd3, 32'hAAAA_5555, 1'b1, 7'h38, 2'd0, 32'h66);
        access("R11 other word read", 1'b0, 7'h38, 2'd3, 32'h0);
    endtask

    initial begin
        t_reset();
        t_core_full();
        t_dma();
        t_partial();
        t_ctl();
        t_invalid();
        t_trunc();
        t_latency();
        t_b2b();
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule